// File: doc/BRIEF.md
# Latched Discrete Input Sampler

This block samples discrete status lines into a word. Each output bit has up to seven input lines. A shared set of seven select strobes chooses one of those lines. The chosen value is not passed straight through to the output. It is held in a storage bit that selection can only set. The storage bit is cleared only when the clear strobe and the block address strobe are asserted together. Every select term is also gated by a clock-phase enable, so no set can happen while that phase is low. The bits are replicated slices. The upper slices leave some inputs unpopulated, and those inputs always read as zero.

A command-source switch is built into the same block. While the ground presence signal is high, the ground command line is routed to the command output. When that signal drops, the radio command line is routed instead. The ground line is routed again once presence returns.

Each storage bit is a two-state machine with the states LATCH_CLR and LATCH_SET:

- The transition LATCH_CLR to LATCH_SET happens when a selected input is 1 while the phase is enabled and no clear is present.
- The transition LATCH_SET to LATCH_CLR happens when a clear is present.

The source switch is a two-state machine with the states SRC_GROUND and SRC_RADIO:

- The transition SRC_GROUND to SRC_RADIO happens when presence is lost.
- The transition SRC_RADIO to SRC_GROUND happens when presence returns.

Top module: `latched_input_sampler`

## Requirements
- R1: After reset, every bit of `q` is 0, `sel_err` is 0 and `cmd_src_radio` is 0.
- R2: Input k of bit b is `din[b*NUM_IN+k]`, and select line k is `sel[k]`. If `phase_en` is 1, `sel[k]` is 1 and that input is 1 at a rising edge, then `q[b]` is 1 from that edge on.
- R3: A selected input that is 0 never clears a bit that is already set.
- R4: While `phase_en` is 0, no bit of `q` is set, whatever the select and input values.
- R5: A bit of `q` clears only at an edge where `clr_stb` and `addr_stb` are both 1. Either strobe alone has no effect.
- R6: When a clear and a set condition occur at the same edge, the clear wins and the bit reads 0.
- R7: If more than one select line is 1, the selected inputs of a bit are ORed. `sel_err` is registered and reads 1 after an edge where `phase_en` was 1 and two or more select lines were 1. Otherwise it reads 0.
- R8: Bits with index FULL_SLICES (default 12) and above populate only inputs 0 to SPARSE_INPUTS-1 (default 4). Their other inputs read as 0 and can never set the bit.
- R9: `cmd_src_radio` reads 1 after any edge at which `gnd_present` was 0, and 0 after any edge at which it was 1.
- R10: `cmd_out` combinationally equals `radio_cmd` while `cmd_src_radio` is 1, and `gnd_cmd` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | 1 | Clock-phase enable that gates all select terms |
| addr_stb | input | 1 | Block address strobe |
| clr_stb | input | 1 | Clear strobe, effective only with `addr_stb` |
| sel | input | NUM_IN | Select strobes, one per input position |
| din | input | WIDTH*NUM_IN | Discrete inputs, bit b input k at b*NUM_IN+k |
| q | output | WIDTH | Held sample word |
| sel_err | output | 1 | More than one select was seen at the last enabled edge |
| gnd_present | input | 1 | Ground link presence |
| gnd_cmd | input | 1 | Command from the ground link |
| radio_cmd | input | 1 | Command from the radio receiver |
| cmd_out | output | 1 | Routed command |
| cmd_src_radio | output | 1 | 1 when the radio line is routed |

## Verification
The assertions assume that all inputs are known, 0 or 1, at every rising edge after reset, and that inputs change only between edges. The bench keeps to this by driving every input one nanosecond after a falling edge, from a single process. Apart from that, the assertions do not assume a one-hot select pattern. For that reason the stimulus deliberately includes multi-select cycles, clear-with-set collisions and presence drops, and the bench's reference model handles all of these.

// File: rtl/lis_pkg.sv
package lis_pkg;

    typedef enum logic {
        LATCH_CLR = 1'b0,
        LATCH_SET = 1'b1
    } latch_state_t;

    typedef enum logic {
        SRC_GROUND = 1'b0,
        SRC_RADIO  = 1'b1
    } src_state_t;

    // Low n bits set: marks which input positions of a slice are fitted.
    function automatic logic [31:0] fitted_mask(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lis_bit_slice.sv
module lis_bit_slice
    import lis_pkg::*;
#(
    parameter int NUM_IN     = 7,
    parameter int POP_INPUTS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_en,
    input  logic              clr_hit,
    input  logic [NUM_IN-1:0] sel,
    input  logic [NUM_IN-1:0] din,
    output logic              q
);

    localparam logic [31:0]       MASK32 = fitted_mask(POP_INPUTS);
    localparam logic [NUM_IN-1:0] FITTED = MASK32[NUM_IN-1:0];

    logic [NUM_IN-1:0] term;
    logic              aoi_n;
    latch_state_t      state_r;
    latch_state_t      state_nx;

    // AND each fitted input with its strobe and the phase, OR, invert.
    always_comb begin
        term  = din & sel & FITTED & {NUM_IN{phase_en}};
        aoi_n = ~(|term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= LATCH_CLR;
        else        state_r <= state_nx;
    end

    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            LATCH_CLR: if (!clr_hit && !aoi_n) state_nx = LATCH_SET;
            LATCH_SET: if (clr_hit)            state_nx = LATCH_CLR;
            default:                           state_nx = LATCH_CLR;
        endcase
    end

    always_comb begin
        q = (state_r == LATCH_SET);
    end

endmodule

// File: rtl/lis_sel_err.sv
module lis_sel_err #(
    parameter int NUM_IN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_en,
    input  logic [NUM_IN-1:0] sel,
    output logic              err
);

    logic multi;

    always_comb begin
        multi = phase_en && ($countones(sel) > 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err <= 1'b0;
        else        err <= multi;
    end

endmodule

// File: rtl/lis_src_switch.sv
module lis_src_switch
    import lis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gnd_present,
    input  logic gnd_cmd,
    input  logic radio_cmd,
    output logic cmd_out,
    output logic on_radio
);

    src_state_t state_r;
    src_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= SRC_GROUND;
        else        state_r <= state_nx;
    end

    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            SRC_GROUND: if (!gnd_present) state_nx = SRC_RADIO;
            SRC_RADIO:  if (gnd_present)  state_nx = SRC_GROUND;
            default:                      state_nx = SRC_GROUND;
        endcase
    end

    always_comb begin
        unique case (state_r)
            SRC_RADIO: begin cmd_out = radio_cmd; on_radio = 1'b1; end
            default:   begin cmd_out = gnd_cmd;   on_radio = 1'b0; end
        endcase
    end

endmodule

// File: rtl/latched_input_sampler.sv
module latched_input_sampler #(
    parameter int WIDTH         = 14,
    parameter int NUM_IN        = 7,
    parameter int FULL_SLICES   = 12,
    parameter int SPARSE_INPUTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     phase_en,
    input  logic                     addr_stb,
    input  logic                     clr_stb,
    input  logic [NUM_IN-1:0]        sel,
    input  logic [WIDTH*NUM_IN-1:0]  din,
    output logic [WIDTH-1:0]         q,
    output logic                     sel_err,
    input  logic                     gnd_present,
    input  logic                     gnd_cmd,
    input  logic                     radio_cmd,
    output logic                     cmd_out,
    output logic                     cmd_src_radio
);

    logic clr_hit;

    always_comb begin
        clr_hit = clr_stb & addr_stb;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b < FULL_SLICES) begin : g_full
            lis_bit_slice #(
                .NUM_IN     (NUM_IN),
                .POP_INPUTS (NUM_IN)
            ) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .phase_en (phase_en),
                .clr_hit  (clr_hit),
                .sel      (sel),
                .din      (din[b*NUM_IN +: NUM_IN]),
                .q        (q[b])
            );
        end else begin : g_sparse
            lis_bit_slice #(
                .NUM_IN     (NUM_IN),
                .POP_INPUTS (SPARSE_INPUTS)
            ) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .phase_en (phase_en),
                .clr_hit  (clr_hit),
                .sel      (sel),
                .din      (din[b*NUM_IN +: NUM_IN]),
                .q        (q[b])
            );
        end
    end

    lis_sel_err #(
        .NUM_IN (NUM_IN)
    ) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_en (phase_en),
        .sel      (sel),
        .err      (sel_err)
    );

    lis_src_switch u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnd_present (gnd_present),
        .gnd_cmd     (gnd_cmd),
        .radio_cmd   (radio_cmd),
        .cmd_out     (cmd_out),
        .on_radio    (cmd_src_radio)
    );

endmodule

// File: rtl/lis_checker.sv
module lis_checker #(
    parameter int WIDTH  = 14,
    parameter int NUM_IN = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase_en,
    input logic              addr_stb,
    input logic              clr_stb,
    input logic [NUM_IN-1:0] sel,
    input logic [WIDTH-1:0]  q,
    input logic              sel_err,
    input logic              gnd_present,
    input logic              gnd_cmd,
    input logic              radio_cmd,
    input logic              cmd_out,
    input logic              cmd_src_radio
);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && addr_stb) |=> (q == '0));

    a_r5_no_lone_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_stb && addr_stb) |=> ((q & $past(q)) == $past(q)));

    a_r4_phase_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_en && !(clr_stb && addr_stb)) |=> $stable(q));

    a_r7_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && ($countones(sel) > 1)) |=> sel_err);

    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_en && ($countones(sel) > 1)) |=> !sel_err);

    a_r9_to_radio: assert property (@(posedge clk) disable iff (!rst_n)
        !gnd_present |=> cmd_src_radio);

    a_r9_to_ground: assert property (@(posedge clk) disable iff (!rst_n)
        gnd_present |=> !cmd_src_radio);

    a_r10_route: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_out == (cmd_src_radio ? radio_cmd : gnd_cmd));

endmodule

bind latched_input_sampler lis_checker #(
    .WIDTH  (WIDTH),
    .NUM_IN (NUM_IN)
) u_lis_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_en      (phase_en),
    .addr_stb      (addr_stb),
    .clr_stb       (clr_stb),
    .sel           (sel),
    .q             (q),
    .sel_err       (sel_err),
    .gnd_present   (gnd_present),
    .gnd_cmd       (gnd_cmd),
    .radio_cmd     (radio_cmd),
    .cmd_out       (cmd_out),
    .cmd_src_radio (cmd_src_radio)
);

// File: tb/tb_latched_input_sampler.sv
`timescale 1ns/1ps
module tb_latched_input_sampler;

    localparam int W  = 14;
    localparam int N  = 7;
    localparam int FS = 12;
    localparam int SI = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           phase_en = 1'b0;
    logic           addr_stb = 1'b0;
    logic           clr_stb = 1'b0;
    logic [N-1:0]   sel = '0;
    logic [W*N-1:0] din = '0;
    logic [W-1:0]   q;
    logic           sel_err;
    logic           gnd_present = 1'b1;
    logic           gnd_cmd = 1'b0;
    logic           radio_cmd = 1'b0;
    logic           cmd_out;
    logic           cmd_src_radio;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    latched_input_sampler dut (
        .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .addr_stb(addr_stb),
        .clr_stb(clr_stb), .sel(sel), .din(din), .q(q), .sel_err(sel_err),
        .gnd_present(gnd_present), .gnd_cmd(gnd_cmd), .radio_cmd(radio_cmd),
        .cmd_out(cmd_out), .cmd_src_radio(cmd_src_radio)
    );

    // Behavioural reference model
    logic [W-1:0] m_q;
    logic         m_err;
    logic         m_radio;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q     <= '0;
            m_err   <= 1'b0;
            m_radio <= 1'b0;
        end else begin
            int nsel;
            logic [W-1:0] nq;
            nsel = 0;
            for (int k = 0; k < N; k++) if (sel[k]) nsel++;
            nq = m_q;
            for (int b = 0; b < W; b++) begin
                logic hit;
                hit = 1'b0;
                for (int k = 0; k < N; k++) begin
                    if (sel[k] && din[b*N+k] && !(b >= FS && k >= SI)) hit = 1'b1;
                end
                if (clr_stb && addr_stb) nq[b] = 1'b0;
                else if (phase_en && hit) nq[b] = 1'b1;
            end
            m_q     <= nq;
            m_err   <= phase_en && (nsel > 1);
            m_radio <= !gnd_present;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 q vs model", 32'(q), 32'(m_q));
            chk("R7 sel_err vs model", 32'(sel_err), 32'(m_err));
            chk("R9 source vs model", 32'(cmd_src_radio), 32'(m_radio));
            chk("R10 cmd_out vs model", 32'(cmd_out), 32'(m_radio ? radio_cmd : gnd_cmd));
        end
    end

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [W*N-1:0] spread(input int k, input logic [W-1:0] v);
        logic [W*N-1:0] r;
        r = '0;
        for (int b = 0; b < W; b++) r[b*N+k] = v[b];
        return r;
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 q after reset", 32'(q), 32'h0);
        chk("R1 sel_err after reset", 32'(sel_err), 32'h0);
        chk("R1 source after reset", 32'(cmd_src_radio), 32'h0);
        #1 rst_n = 1'b1;
        tick;

        // R2: single select, pattern on input 0
        #1 phase_en = 1'b1; sel = 7'b0000001; din = spread(0, 14'h2A5C);
        tick;
        chk("R2 set from input 0", 32'(q), 32'h2A5C);

        // R3: selected input falls to 0, bits stay
        #1 din = '0;
        tick;
        chk("R3 hold after input drops", 32'(q), 32'h2A5C);

        // R5: lone strobes do not clear
        #1 clr_stb = 1'b1;
        tick;
        chk("R5 clear without address", 32'(q), 32'h2A5C);
        #1 clr_stb = 1'b0; addr_stb = 1'b1;
        tick;
        chk("R5 address without clear", 32'(q), 32'h2A5C);
        #1 clr_stb = 1'b1;
        tick;
        chk("R5 clear with address", 32'(q), 32'h0);
        #1 clr_stb = 1'b0; addr_stb = 1'b0;

        // R4: phase low blocks setting
        phase_en = 1'b0; sel = 7'b0001000; din = spread(3, 14'h3FFF);
        tick;
        tick;
        chk("R4 no set while phase low", 32'(q), 32'h0);

        // R6: clear wins over a set at the same edge
        #1 phase_en = 1'b1; clr_stb = 1'b1; addr_stb = 1'b1;
        tick;
        chk("R6 clear beats set", 32'(q), 32'h0);
        #1 clr_stb = 1'b0; addr_stb = 1'b0; sel = '0; din = '0;
        tick;

        // R7: two selects are ORed and flagged
        #1 sel = 7'b0100010; din = spread(1, 14'h0013) | spread(5, 14'h0240);
        tick;
        chk("R7 ORed inputs", 32'(q), 32'h0253);
        chk("R7 error flag raised", 32'(sel_err), 32'h1);
        #1 sel = 7'b0000010;
        tick;
        chk("R7 error flag drops", 32'(sel_err), 32'h0);
        #1 phase_en = 1'b0; sel = 7'b1100000;
        tick;
        chk("R7 no flag while phase low", 32'(sel_err), 32'h0);

        // R8: sparse slices ignore upper inputs
        #1 phase_en = 1'b1; clr_stb = 1'b1; addr_stb = 1'b1; sel = '0; din = '0;
        tick;
        #1 clr_stb = 1'b0; addr_stb = 1'b0; sel = 7'b1000000; din = spread(6, 14'h3FFF);
        tick;
        chk("R8 input 6 unfitted on top bits", 32'(q), 32'h0FFF);
        #1 sel = 7'b0000100; din = spread(2, 14'h3000);
        tick;
        chk("R8 input 2 fitted on top bits", 32'(q), 32'h3FFF);

        // R9/R10: source switchover
        #1 gnd_cmd = 1'b1; radio_cmd = 1'b0; sel = '0; din = '0;
        #1 chk("R10 ground routed", 32'(cmd_out), 32'h1);
        gnd_present = 1'b0;
        tick;
        chk("R9 radio after presence lost", 32'(cmd_src_radio), 32'h1);
        chk("R10 radio line routed", 32'(cmd_out), 32'h0);
        #1 radio_cmd = 1'b1;
        #1 chk("R10 follows radio combinationally", 32'(cmd_out), 32'h1);
        gnd_present = 1'b1; radio_cmd = 1'b0;
        tick;
        chk("R9 back to ground", 32'(cmd_src_radio), 32'h0);
        chk("R10 ground line again", 32'(cmd_out), 32'h1);

        // mixed traffic compared against the model each cycle
        for (int i = 0; i < 40; i++) begin
            #1 sel = 7'(1 << (i % N)) | ((i % 5 == 0) ? 7'b0000100 : 7'b0);
            din = {(W*N/32+1){32'h9E3779B9 * (i + 1)}} >> (i % 3);
            phase_en = (i % 4) != 3;
            clr_stb = (i % 7) == 0;
            addr_stb = (i % 7) == 0 || (i % 6) == 0;
            gnd_present = (i % 9) < 6;
            gnd_cmd = i[0];
            radio_cmd = i[1];
            tick;
        end

        #1 phase_en = 1'b0; clr_stb = 1'b0; addr_stb = 1'b0;
        tick;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule